// File: doc/BRIEF.md
# Two-bit instruction-driven ALU

This block is a combinational arithmetic/logic unit for two unsigned 2-bit operands. A 2-bit instruction code selects one of four operations:

- bitwise inversion of the first operand;
- bitwise AND of both operands;
- addition;
- subtraction of the first operand from the second.

The 2-bit result is always the low two bits of the chosen operation. A separate error line rises when an addition or subtraction has a true value that does not fit in two bits.

The instruction is decoded into four one-hot select lines. Each result bit is then formed as an OR of AND terms, one term per decoded instruction. No multiplexer construct is used. Results change as soon as the inputs change, since the block has no clock, no storage and no reset.

Top module: `duo_alu`

## Requirements
- R1: With `instr` = 2'b00, `result` equals the bitwise inverse of `opnd_a`, and `opnd_b` has no effect on it.
- R2: With `instr` = 2'b01, `result` equals `opnd_a & opnd_b`, bit by bit.
- R3: With `instr` = 2'b10, `result` equals (`opnd_a` + `opnd_b`) mod 4.
- R4: With `instr` = 2'b11, `result` equals (`opnd_b` − `opnd_a`) mod 4.
- R5: With `instr` = 2'b10, `err_flag` is 1 exactly when `opnd_a` + `opnd_b` > 3.
- R6: With `instr` = 2'b11, `err_flag` is 1 exactly when `opnd_b` < `opnd_a`.
- R7: With `instr` = 2'b00 or 2'b01, `err_flag` is 0.
- R8: The outputs depend only on the present inputs. A new input value gives the matching output within the same clock cycle, whatever the inputs were before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 2 | First unsigned operand |
| opnd_b | input | 2 | Second unsigned operand |
| instr | input | 2 | Operation code: 00 invert A, 01 AND, 10 add, 11 B minus A |
| result | output | 2 | Low two bits of the selected operation |
| err_flag | output | 1 | Result of add or subtract does not fit in two bits |

## Verification
The whole input space of 64 combinations is swept against an independent arithmetic model. This sweep shows whether each code reaches its own operation, and whether `opnd_b` leaks into the inversion result. A short table of corner vectors then targets the points where wrap and error must coincide: 3+3, 2+2 and 0−1 wrap and raise the flag, while 1+2, 3−3 and 3−0 stay just inside range. The vectors are applied back to back with no idle cycle between them, and inputs are changed from a high-error case to a clean one. This shows that nothing is held over from the previous vector.

// File: rtl/duo_alu_pkg.sv
package duo_alu_pkg;
    localparam int OPW     = 2;
    localparam int NUM_OPS = 1 << OPW;

    typedef enum logic [OPW-1:0] {
        OP_INV = 2'b00,
        OP_AND = 2'b01,
        OP_ADD = 2'b10,
        OP_SUB = 2'b11
    } alu_op_e;
endpackage

// File: rtl/duo_alu_opdec.sv
module duo_alu_opdec
    import duo_alu_pkg::*;
#(
    parameter int CW = OPW,
    localparam int NH = 1 << CW
) (
    input  logic [CW-1:0] op_code,
    output logic [NH-1:0] op_hot
);
    for (genvar k = 0; k < NH; k++) begin : g_term
        localparam logic [CW-1:0] KV = CW'(k);
        assign op_hot[k] = (op_code == KV);
    end

    always_comb begin
        p_onehot_sel_r8: assert ($onehot(op_hot))
            else $error("decoder select not one-hot");
    end
endmodule

// File: rtl/duo_alu_bitwise.sv
module duo_alu_bitwise #(
    parameter int W = 2
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] inv_v,
    output logic [W-1:0] and_v
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign inv_v[i] = ~a_in[i];
        assign and_v[i] = a_in[i] & b_in[i];
    end
endmodule

// File: rtl/duo_alu_arith.sv
module duo_alu_arith #(
    parameter int W = 2
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] sum_v,
    output logic         sum_ovf,
    output logic [W-1:0] dif_v,
    output logic         dif_brw
);
    logic [W:0] cs;
    logic [W:0] cd;

    assign cs[0] = 1'b0;
    assign cd[0] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_fa
        logic na;
        assign na       = ~a_in[i];
        assign sum_v[i] = a_in[i] ^ b_in[i] ^ cs[i];
        assign cs[i+1]  = (a_in[i] & b_in[i]) | (cs[i] & (a_in[i] ^ b_in[i]));
        assign dif_v[i] = b_in[i] ^ na ^ cd[i];
        assign cd[i+1]  = (b_in[i] & na) | (cd[i] & (b_in[i] ^ na));
    end

    assign sum_ovf = cs[W];
    assign dif_brw = ~cd[W];

    always_comb begin
        p_add_chain_r5: assert ({sum_ovf, sum_v} == ({1'b0, a_in} + {1'b0, b_in}))
            else $error("adder chain mismatch");
        p_borrow_r6: assert (dif_brw == (b_in < a_in))
            else $error("borrow mismatch");
    end
endmodule

// File: rtl/duo_alu_select.sv
module duo_alu_select
    import duo_alu_pkg::*;
#(
    parameter int W = 2
) (
    input  logic [NUM_OPS-1:0] op_hot,
    input  logic [W-1:0]       inv_v,
    input  logic [W-1:0]       and_v,
    input  logic [W-1:0]       sum_v,
    input  logic               sum_ovf,
    input  logic [W-1:0]       dif_v,
    input  logic               dif_brw,
    output logic [W-1:0]       res_v,
    output logic               err_v
);
    for (genvar i = 0; i < W; i++) begin : g_sop
        assign res_v[i] = (op_hot[OP_INV] & inv_v[i])
                        | (op_hot[OP_AND] & and_v[i])
                        | (op_hot[OP_ADD] & sum_v[i])
                        | (op_hot[OP_SUB] & dif_v[i]);
    end

    assign err_v = (op_hot[OP_ADD] & sum_ovf) | (op_hot[OP_SUB] & dif_brw);
endmodule

// File: rtl/duo_alu.sv
module duo_alu
    import duo_alu_pkg::*;
#(
    parameter int W = 2
) (
    input  logic [W-1:0]   opnd_a,
    input  logic [W-1:0]   opnd_b,
    input  logic [OPW-1:0] instr,
    output logic [W-1:0]   result,
    output logic           err_flag
);
    localparam int NH = 1 << OPW;

    logic [NH-1:0] op_hot;
    logic [W-1:0]  inv_v, and_v, sum_v, dif_v;
    logic          sum_ovf, dif_brw;

    duo_alu_opdec #(.CW(OPW)) u_dec (
        .op_code (instr),
        .op_hot  (op_hot)
    );

    duo_alu_bitwise #(.W(W)) u_bit (
        .a_in  (opnd_a),
        .b_in  (opnd_b),
        .inv_v (inv_v),
        .and_v (and_v)
    );

    duo_alu_arith #(.W(W)) u_ari (
        .a_in    (opnd_a),
        .b_in    (opnd_b),
        .sum_v   (sum_v),
        .sum_ovf (sum_ovf),
        .dif_v   (dif_v),
        .dif_brw (dif_brw)
    );

    duo_alu_select #(.W(W)) u_sel (
        .op_hot  (op_hot),
        .inv_v   (inv_v),
        .and_v   (and_v),
        .sum_v   (sum_v),
        .sum_ovf (sum_ovf),
        .dif_v   (dif_v),
        .dif_brw (dif_brw),
        .res_v   (result),
        .err_v   (err_flag)
    );

    always_comb begin
        unique case (alu_op_e'(instr))
            OP_INV: begin
                p_inv_r1: assert (result == ~opnd_a) else $error("invert wrong");
                p_quiet_inv_r7: assert (!err_flag) else $error("flag on invert");
            end
            OP_AND: begin
                p_and_r2: assert (result == (opnd_a & opnd_b)) else $error("and wrong");
                p_quiet_and_r7: assert (!err_flag) else $error("flag on and");
            end
            OP_ADD: begin
                p_add_r3: assert (result == W'(opnd_a + opnd_b)) else $error("add wrong");
                p_add_ovf_r5: assert (err_flag == ((32'(opnd_a) + 32'(opnd_b)) > ((1 << W) - 1)))
                    else $error("add flag wrong");
            end
            OP_SUB: begin
                p_sub_r4: assert (result == W'(opnd_b - opnd_a)) else $error("sub wrong");
                p_sub_neg_r6: assert (err_flag == (opnd_b < opnd_a)) else $error("sub flag wrong");
            end
            default: ;
        endcase
    end
endmodule

// File: tb/duo_alu_bench.sv
module duo_alu_bench;
    logic       clk = 1'b0;
    logic [1:0] opnd_a = 2'd0, opnd_b = 2'd0, instr = 2'd0;
    logic [1:0] result;
    logic       err_flag;
    int         total = 0, bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    duo_alu u_duo_alu (
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .instr    (instr),
        .result   (result),
        .err_flag (err_flag)
    );

    typedef struct packed {
        logic [1:0] a;
        logic [1:0] b;
        logic [1:0] i;
        logic [1:0] f;
        logic       e;
    } vec_t;

    localparam vec_t CORNER [8] = '{
        '{2'd3, 2'd3, 2'b10, 2'd2, 1'b1},
        '{2'd1, 2'd2, 2'b10, 2'd3, 1'b0},
        '{2'd2, 2'd2, 2'b10, 2'd0, 1'b1},
        '{2'd1, 2'd0, 2'b11, 2'd3, 1'b1},
        '{2'd3, 2'd3, 2'b11, 2'd0, 1'b0},
        '{2'd0, 2'd3, 2'b11, 2'd3, 1'b0},
        '{2'd2, 2'd1, 2'b00, 2'd1, 1'b0},
        '{2'd3, 2'd2, 2'b01, 2'd2, 1'b0}
    };

    function automatic string tag_of(input logic [1:0] i, input bit flag);
        case (i)
            2'b00:   return flag ? "R7" : "R1";
            2'b01:   return flag ? "R7" : "R2";
            2'b10:   return flag ? "R5" : "R3";
            default: return flag ? "R6" : "R4";
        endcase
    endfunction

    task automatic apply_and_check(input logic [1:0] a, input logic [1:0] b, input logic [1:0] i,
                                   input logic [1:0] ef, input logic ee, input string note);
        @(negedge clk);
        opnd_a = a; opnd_b = b; instr = i;
        #1;
        total++;
        if (result !== ef) begin
            bad++;
            $display("FAIL %s %s a=%0d b=%0d i=%b result actual=%0d expected=%0d",
                     tag_of(i, 1'b0), note, a, b, i, result, ef);
        end
        total++;
        if (err_flag !== ee) begin
            bad++;
            $display("FAIL %s %s a=%0d b=%0d i=%b err_flag actual=%0d expected=%0d",
                     tag_of(i, 1'b1), note, a, b, i, err_flag, ee);
        end
    endtask

    initial begin
        // idle state with all-zero inputs: invert of 0 gives 3, flag low (R1, R7)
        #1;
        total++;
        if (result !== 2'd3 || err_flag !== 1'b0) begin
            bad++;
            $display("FAIL R1 idle result actual=%0d/%0d expected=3/0", result, err_flag);
        end

        // full sweep against the model, consecutive vectors, no idle cycle (R1-covering, R8)
        for (int i = 0; i < 4; i++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    int   ef;
                    logic ee;
                    case (i)
                        0: begin ef = (~a) & 3;      ee = 1'b0; end
                        1: begin ef = a & b;         ee = 1'b0; end
                        2: begin ef = (a + b) % 4;   ee = (a + b) > 3; end
                        default: begin ef = (b - a + 4) % 4; ee = b < a; end
                    endcase
                    apply_and_check(2'(a), 2'(b), 2'(i), 2'(ef), ee, "sweep R8");
                end
            end
        end

        // corner table: wrap with flag, and just-in-range without flag (R3 R4 R5 R6)
        foreach (CORNER[k]) begin
            apply_and_check(CORNER[k].a, CORNER[k].b, CORNER[k].i,
                            CORNER[k].f, CORNER[k].e, "corner");
        end

        // R1: B has no effect on invert, with B swung across all values
        apply_and_check(2'd1, 2'd0, 2'b00, 2'd2, 1'b0, "R1 b0");
        apply_and_check(2'd1, 2'd3, 2'b00, 2'd2, 1'b0, "R1 b3");

        // R8: flagged case followed straight by a clean one, nothing held over
        apply_and_check(2'd3, 2'd0, 2'b11, 2'd1, 1'b1, "R8 before");
        apply_and_check(2'd0, 2'd0, 2'b01, 2'd0, 1'b0, "R8 after");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule